// File: doc/BRIEF.md
# PIO Drive Cycle Timing Sequencer

This block runs one programmed-I/O transfer against a parallel ATA-style drive and counts every phase in host clock cycles. A request supplies the register address, the chip-select choice, the direction, the size, a timing class and the fast-class sample and recovery settings. The block then drives the address lines, one active-low chip select and one active-low strobe. It samples the drive's ready line and returns read data together with a one-cycle completion pulse.

There are three timing classes. The two compatible classes (register and data) use fixed phase lengths. The fast class has a short fixed startup and programmable sample and recovery lengths. A 32-bit request to the data register becomes two 16-bit drive cycles in every class. In the compatible classes, a full shutdown and a chip-select gap come before a new startup for the second half. In the fast class, the second strobe follows the first half's recovery directly.

A request is taken only while `busy` is low. Request fields and settings are captured on the accepting edge.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset, both chip selects and both strobes are high (`drv_cs_n` = 2'b11), `drv_oe`, `done`, `busy` and `rd_data` are all zero.
- R2: Taking a request on clock edge E0 asserts the chip select and address from E0. The strobe asserts at edge E0+SU, where SU is 4 for class 0 (register, compatible), 3 for class 1 (data, compatible) and 2 for classes 2 and 3 (fast). `req_sel`=0 selects `drv_cs_n[0]` and `req_sel`=1 selects `drv_cs_n[1]`. `drv_rd_n` strobes reads and `drv_wr_n` strobes writes.
- R3: When ready is high, the strobe stays low for SP cycles. SP is 11 for class 0, 6 for class 1, and 2+`cfg_isp` for the fast classes.
- R4: After the strobe rises, the chip select and address are held for RC+2 cycles, where RC is 22, 14 or 1+`cfg_rct`. On the next edge the chip select is released and `done` pulses high for exactly one cycle. `busy` is high from E0 up to that edge.
- R5: If ready is low at the sample edge and is not masked, the strobe stays low. Ready is sampled again at each edge, and the strobe rises on the first edge that sees ready high.
- R6: When `cfg_rdy_mask[req_drive]` is 1, the ready line is ignored and the strobe rises at the first sample edge.
- R7: A 32-bit request (`req_wide`=1) with `req_sel`=0 and `req_addr`=0 runs two 16-bit drive cycles and pulses `done` only after the second one. Any other address runs a single cycle.
- R8: In classes 0 and 1, the first half of a split ends with its full shutdown. The chip select is then high for exactly 2 cycles before the second half's startup.
- R9: In the fast classes, the second half's strobe starts right after the first half's recovery. The chip select stays asserted between the halves.
- R10: Read data is captured on the edge where the strobe rises. The first half fills bits 15:0 and the second half fills bits 31:16. A 16-bit read returns zero in bits 31:16. `rd_data` holds until the next request is taken.
- R11: On a write, `drv_oe` is high exactly while the chip select is asserted. `drv_wdata` carries bits 15:0 for the first half and bits 31:16 for the second.
- R12: A request presented while `busy` is high is ignored, and the running cycle is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 32-bit host access |
| req_sel | input | 1 | 0 command-block select, 1 control-block select |
| req_addr | input | 3 | Drive register address |
| req_class | input | 2 | 0 register compatible, 1 data compatible, 2/3 fast |
| req_drive | input | 1 | Drive number, picks the ready-mask bit |
| req_wdata | input | 32 | Write data |
| cfg_isp | input | 2 | Fast sample point setting |
| cfg_rct | input | 2 | Fast recovery setting |
| cfg_rdy_mask | input | 2 | Per-drive ready-ignore bits |
| drv_ready | input | 1 | Drive ready line |
| drv_rdata | input | 16 | Data bus from the drive |
| busy | output | 1 | Cycle in progress |
| drv_addr | output | 3 | Address lines |
| drv_cs_n | output | 2 | Active-low chip selects |
| drv_rd_n | output | 1 | Active-low read strobe |
| drv_wr_n | output | 1 | Active-low write strobe |
| drv_wdata | output | 16 | Data bus toward the drive |
| drv_oe | output | 1 | Data bus drive enable |
| rd_data | output | 32 | Assembled read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `drv_ready` is a synchronous level that is stable around each clock edge. They also assume that `req_valid` is acted on only in the idle state. The stimulus changes ready and the read bus half a clock away from the active edge, and it models the drive as raising ready a chosen number of cycles into the strobe. Garbage is placed on the read bus except in the cycle that ends the strobe. Requests are issued only after `done`, except in one directed case that presents a conflicting request mid-cycle to exercise the ignore rule.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_STROBE, ST_RECOV, ST_SHUT, ST_GAP
  } pio_state_e;

  localparam logic [1:0] CLS_REG  = 2'd0;
  localparam logic [1:0] CLS_DATA = 2'd1;
endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel #(
  parameter int CNT_W        = 5,
  parameter int CFG_W        = 2,
  parameter int REG_SU       = 4,
  parameter int REG_SP       = 11,
  parameter int REG_RC       = 22,
  parameter int DAT_SU       = 3,
  parameter int DAT_SP       = 6,
  parameter int DAT_RC       = 14,
  parameter int FAST_SU      = 2,
  parameter int FAST_SP_BASE = 2,
  parameter int FAST_RC_BASE = 1
) (
  input  logic [1:0]       cls,
  input  logic [CFG_W-1:0] cfg_sp,
  input  logic [CFG_W-1:0] cfg_rc,
  output logic [CNT_W-1:0] len_su,
  output logic [CNT_W-1:0] len_sp,
  output logic [CNT_W-1:0] len_rc
);
  import pio_pkg::*;

  always_comb begin
    case (cls)
      CLS_REG: begin
        len_su = CNT_W'(REG_SU);
        len_sp = CNT_W'(REG_SP);
        len_rc = CNT_W'(REG_RC);
      end
      CLS_DATA: begin
        len_su = CNT_W'(DAT_SU);
        len_sp = CNT_W'(DAT_SP);
        len_rc = CNT_W'(DAT_RC);
      end
      default: begin
        len_su = CNT_W'(FAST_SU);
        len_sp = CNT_W'(FAST_SP_BASE) + CNT_W'(cfg_sp);
        len_rc = CNT_W'(FAST_RC_BASE) + CNT_W'(cfg_rc);
      end
    endcase
  end
endmodule

// File: rtl/pio_rdata_pack.sv
module pio_rdata_pack #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            cap,
  input  logic            upper,
  input  logic [DW-1:0]   din,
  output logic [2*DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      dout <= '0;
    end else if (cap) begin
      if (upper) dout[2*DW-1:DW] <= din;
      else       dout[DW-1:0]    <= din;
    end
  end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq #(
  parameter int DW           = 16,
  parameter int AW           = 3,
  parameter int CNT_W        = 5,
  parameter int CFG_W        = 2,
  parameter int REG_SU       = 4,
  parameter int REG_SP       = 11,
  parameter int REG_RC       = 22,
  parameter int DAT_SU       = 3,
  parameter int DAT_SP       = 6,
  parameter int DAT_RC       = 14,
  parameter int FAST_SU      = 2,
  parameter int FAST_SP_BASE = 2,
  parameter int FAST_RC_BASE = 1,
  parameter int SHUT_LEN     = 2,
  parameter int GAP_LEN      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic              req_sel,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_class,
  input  logic              req_drive,
  input  logic [2*DW-1:0]   req_wdata,
  input  logic [CFG_W-1:0]  cfg_isp,
  input  logic [CFG_W-1:0]  cfg_rct,
  input  logic [1:0]        cfg_rdy_mask,
  input  logic              drv_ready,
  input  logic [DW-1:0]     drv_rdata,
  output logic              busy,
  output logic [AW-1:0]     drv_addr,
  output logic [1:0]        drv_cs_n,
  output logic              drv_rd_n,
  output logic              drv_wr_n,
  output logic [DW-1:0]     drv_wdata,
  output logic              drv_oe,
  output logic [2*DW-1:0]   rd_data,
  output logic              done
);
  import pio_pkg::*;

  localparam int WW = 2 * DW;

  pio_state_e       state, nst;
  logic [CNT_W-1:0] cnt, ncnt;
  logic             half, nhalf, ndone, cap;
  logic [CNT_W-1:0] t_su, t_sp, t_rc;
  logic [CNT_W-1:0] l_su, l_sp, l_rc;
  logic             l_write, l_sel, l_two, l_compat, l_masked;
  logic [AW-1:0]    l_addr;
  logic [WW-1:0]    l_wdata;

  logic             accept, cur_write, cur_sel, act;
  logic [AW-1:0]    cur_addr;
  logic [WW-1:0]    cur_wdata;

  pio_timing_sel #(
    .CNT_W(CNT_W), .CFG_W(CFG_W),
    .REG_SU(REG_SU), .REG_SP(REG_SP), .REG_RC(REG_RC),
    .DAT_SU(DAT_SU), .DAT_SP(DAT_SP), .DAT_RC(DAT_RC),
    .FAST_SU(FAST_SU), .FAST_SP_BASE(FAST_SP_BASE), .FAST_RC_BASE(FAST_RC_BASE)
  ) u_tsel (
    .cls(req_class), .cfg_sp(cfg_isp), .cfg_rc(cfg_rct),
    .len_su(t_su), .len_sp(t_sp), .len_rc(t_rc)
  );

  pio_rdata_pack #(.DW(DW)) u_pack (
    .clk(clk), .rst(rst), .clear(accept), .cap(cap),
    .upper(half), .din(drv_rdata), .dout(rd_data)
  );

  assign accept    = (state == ST_IDLE) && req_valid;
  assign cur_write = accept ? req_write : l_write;
  assign cur_sel   = accept ? req_sel   : l_sel;
  assign cur_addr  = accept ? req_addr  : l_addr;
  assign cur_wdata = accept ? req_wdata : l_wdata;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    nst   = state;
    ncnt  = cnt;
    nhalf = half;
    ndone = 1'b0;
    cap   = 1'b0;
    case (state)
      ST_IDLE: if (req_valid) begin
        nst   = ST_START;
        ncnt  = t_su - 1'b1;
        nhalf = 1'b0;
      end
      ST_START: if (cnt != '0) ncnt = cnt - 1'b1;
        else begin nst = ST_STROBE; ncnt = l_sp - 1'b1; end
      ST_STROBE: if (cnt != '0) ncnt = cnt - 1'b1;
        else if (drv_ready || l_masked) begin
          nst  = ST_RECOV;
          ncnt = l_rc - 1'b1;
          cap  = !l_write;
        end
      ST_RECOV: if (cnt != '0) ncnt = cnt - 1'b1;
        else if (l_two && !half && !l_compat) begin
          nst   = ST_STROBE;
          ncnt  = l_sp - 1'b1;
          nhalf = 1'b1;
        end else begin
          nst  = ST_SHUT;
          ncnt = CNT_W'(SHUT_LEN - 1);
        end
      ST_SHUT: if (cnt != '0) ncnt = cnt - 1'b1;
        else if (l_two && !half) begin
          nst   = ST_GAP;
          ncnt  = CNT_W'(GAP_LEN - 1);
          nhalf = 1'b1;
        end else begin
          nst   = ST_IDLE;
          ndone = 1'b1;
        end
      ST_GAP: if (cnt != '0) ncnt = cnt - 1'b1;
        else begin nst = ST_START; ncnt = l_su - 1'b1; end
      default: nst = ST_IDLE;
    endcase
  end

  assign act = (nst == ST_START) || (nst == ST_STROBE) ||
               (nst == ST_RECOV) || (nst == ST_SHUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      half      <= 1'b0;
      done      <= 1'b0;
      drv_cs_n  <= 2'b11;
      drv_rd_n  <= 1'b1;
      drv_wr_n  <= 1'b1;
      drv_addr  <= '0;
      drv_oe    <= 1'b0;
      drv_wdata <= '0;
      l_su <= '0; l_sp <= '0; l_rc <= '0;
      l_write <= 1'b0; l_sel <= 1'b0; l_two <= 1'b0;
      l_compat <= 1'b0; l_masked <= 1'b0;
      l_addr <= '0; l_wdata <= '0;
    end else begin
      state <= nst;
      cnt   <= ncnt;
      half  <= nhalf;
      done  <= ndone;
      if (accept) begin
        l_su     <= t_su;
        l_sp     <= t_sp;
        l_rc     <= t_rc;
        l_write  <= req_write;
        l_sel    <= req_sel;
        l_addr   <= req_addr;
        l_wdata  <= req_wdata;
        l_two    <= req_wide && !req_sel && (req_addr == '0);
        l_compat <= !req_class[1];
        l_masked <= cfg_rdy_mask[req_drive];
      end
      drv_cs_n  <= act ? (cur_sel ? 2'b01 : 2'b10) : 2'b11;
      drv_addr  <= act ? cur_addr : '0;
      drv_rd_n  <= !((nst == ST_STROBE) && !cur_write);
      drv_wr_n  <= !((nst == ST_STROBE) && cur_write);
      drv_oe    <= act && cur_write;
      drv_wdata <= (act && cur_write) ? (nhalf ? cur_wdata[WW-1:DW] : cur_wdata[DW-1:0]) : '0;
    end
  end

  assert_idle_pins_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (drv_cs_n == 2'b11 && drv_rd_n && drv_wr_n && !drv_oe));
  assert_strobe_under_cs_R2: assert property (@(posedge clk) disable iff (rst)
    (!drv_rd_n || !drv_wr_n) |-> (drv_cs_n != 2'b11));
  assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~drv_cs_n));
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (drv_rd_n || drv_wr_n));
  assert_hold_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(drv_rd_n) || $rose(drv_wr_n)) |-> (drv_cs_n != 2'b11));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_wait_extends_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STROBE && cnt == '0 && !drv_ready && !l_masked) |=> (state == ST_STROBE));
  assert_mask_ignores_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STROBE && cnt == '0 && l_masked) |=> (state == ST_RECOV));
  assert_gap_released_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> (drv_cs_n == 2'b11));
  assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid && state != ST_SHUT) |=> busy);
endmodule

// File: tb/pio_cycle_seq_test.sv
`timescale 1ns/1ps
module pio_cycle_seq_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_wide, req_sel, req_drive;
  logic [2:0]  req_addr;
  logic [1:0]  req_class, cfg_isp, cfg_rct, cfg_rdy_mask;
  logic [31:0] req_wdata;
  logic        drv_ready;
  logic [15:0] drv_rdata;
  logic        busy, drv_rd_n, drv_wr_n, drv_oe, done;
  logic [2:0]  drv_addr;
  logic [1:0]  drv_cs_n;
  logic [15:0] drv_wdata;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pio_cycle_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_sel(req_sel), .req_addr(req_addr),
    .req_class(req_class), .req_drive(req_drive), .req_wdata(req_wdata),
    .cfg_isp(cfg_isp), .cfg_rct(cfg_rct), .cfg_rdy_mask(cfg_rdy_mask),
    .drv_ready(drv_ready), .drv_rdata(drv_rdata), .busy(busy),
    .drv_addr(drv_addr), .drv_cs_n(drv_cs_n), .drv_rd_n(drv_rd_n),
    .drv_wr_n(drv_wr_n), .drv_wdata(drv_wdata), .drv_oe(drv_oe),
    .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int su_of(input logic [1:0] cls);
    return (cls == 2'd0) ? 4 : (cls == 2'd1) ? 3 : 2;
  endfunction
  function automatic int sp_of(input logic [1:0] cls, input logic [1:0] cfg);
    return (cls == 2'd0) ? 11 : (cls == 2'd1) ? 6 : 2 + int'(cfg);
  endfunction
  function automatic int rc_of(input logic [1:0] cls, input logic [1:0] cfg);
    return (cls == 2'd0) ? 22 : (cls == 2'd1) ? 14 : 1 + int'(cfg);
  endfunction

  task automatic run_txn(input bit wr, input bit wide, input bit sel, input logic [2:0] addr,
                         input logic [1:0] cls, input bit drive, input logic [1:0] ci,
                         input logic [1:0] cr, input logic [1:0] mk, input int wt,
                         input logic [31:0] wd, input logic [15:0] lo, input logic [15:0] hi,
                         input bit poke);
    bit e_cs[256];
    bit e_stb[256];
    int e_half[256];
    int t, nh, su, sp, rc, tend, c, hcnt, tmis, wmis, fin;
    bit compat, msk, stb, prev, csa;
    logic [31:0] rdo, rexp;
    string tag;
    for (int i = 0; i < 256; i++) begin e_cs[i] = 0; e_stb[i] = 0; e_half[i] = 0; end
    nh = (wide && !sel && addr == 3'd0) ? 2 : 1;
    compat = !cls[1];
    msk = mk[drive];
    su = su_of(cls); sp = sp_of(cls, ci); rc = rc_of(cls, cr);
    fin = msk ? sp : sp + wt;
    t = 1;
    for (int h = 0; h < nh; h++) begin
      if (h == 0 || compat) begin
        if (h == 1) t += 2;
        for (int k = 0; k < su; k++) begin e_cs[t] = 1; t++; end
      end
      for (int k = 0; k < fin; k++) begin e_cs[t] = 1; e_stb[t] = 1; e_half[t] = h; t++; end
      for (int k = 0; k < rc; k++) begin e_cs[t] = 1; t++; end
      if (h == nh - 1 || compat)
        for (int k = 0; k < 2; k++) begin e_cs[t] = 1; t++; end
    end
    tend = t;
    tag = "R2 R3 R4";
    if (wt > 0 && !msk) tag = {tag, " R5"};
    if (msk) tag = {tag, " R6"};
    if (wide) tag = {tag, " R7"};
    if (nh == 2) tag = {tag, compat ? " R8" : " R9"};
    if (poke) tag = {tag, " R12"};

    req_write = wr; req_wide = wide; req_sel = sel; req_addr = addr;
    req_class = cls; req_drive = drive; cfg_isp = ci; cfg_rct = cr;
    cfg_rdy_mask = mk; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    c = 0; hcnt = 0; prev = 0; tmis = 0; wmis = 0; rdo = '0;
    for (t = 1; t <= tend + 1; t++) begin
      csa = (drv_cs_n != 2'b11);
      stb = wr ? !drv_wr_n : !drv_rd_n;
      if (csa != e_cs[t] || stb != e_stb[t] || done != (t == tend) ||
          busy != (t < tend) || (wr ? !drv_rd_n : !drv_wr_n)) tmis++;
      if (csa && (drv_addr != addr || drv_cs_n != (sel ? 2'b01 : 2'b10))) tmis++;
      if (drv_oe != (wr && e_cs[t])) wmis++;
      if (wr && e_stb[t] && drv_wdata != (e_half[t] != 0 ? wd[31:16] : wd[15:0])) wmis++;
      if (t == tend) rdo = rd_data;
      if (stb && !prev) hcnt++;
      prev = stb;
      c = stb ? c + 1 : 0;
      drv_ready = stb ? (c >= sp + wt) : 1'b1;
      drv_rdata = (stb && c == fin) ? ((hcnt == 2) ? hi : lo) : 16'($urandom);
      if (poke && t == 5) begin req_valid = 1'b1; req_addr = ~addr; req_write = ~wr; req_sel = ~sel; end
      if (poke && t == 6) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(tmis == 0, {tag, " pin timing"}, tmis, 0);
    if (wr) chk(wmis == 0, "R11 write bus", wmis, 0);
    else begin
      rexp = (nh == 2) ? {hi, lo} : {16'h0, lo};
      chk(rdo == rexp, "R10 read data", rdo, rexp);
      chk(wmis == 0, "R11 bus idle on read", wmis, 0);
    end
    if (poke) begin
      tmis = 0;
      for (int k = 0; k < 6; k++) begin
        if (busy || drv_cs_n != 2'b11) tmis++;
        @(negedge clk);
      end
      chk(tmis == 0, "R12 ignored request stays ignored", tmis, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0; req_sel = 1'b0;
    req_addr = '0; req_class = '0; req_drive = 1'b0; req_wdata = '0;
    cfg_isp = '0; cfg_rct = '0; cfg_rdy_mask = '0; drv_ready = 1'b1; drv_rdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(drv_cs_n == 2'b11 && drv_rd_n && drv_wr_n, "R1 pins idle", {drv_cs_n, drv_rd_n, drv_wr_n}, 4'hF);
    chk(!done && !busy && !drv_oe, "R1 status low", {done, busy, drv_oe}, 0);
    chk(rd_data == 32'h0, "R1 read data cleared", rd_data, 0);

    run_txn(0, 0, 0, 3'd7, 2'd0, 0, 2'd0, 2'd0, 2'b00, 0, 32'h0, 16'h1357, 16'h0, 0);
    run_txn(1, 0, 1, 3'd6, 2'd1, 1, 2'd0, 2'd0, 2'b00, 0, 32'hAAAA_5A5A, 16'h0, 16'h0, 0);
    run_txn(0, 0, 0, 3'd2, 2'd2, 0, 2'd0, 2'd0, 2'b00, 0, 32'h0, 16'hBEEF, 16'h0, 0);
    run_txn(0, 0, 0, 3'd3, 2'd3, 0, 2'd3, 2'd3, 2'b00, 0, 32'h0, 16'hC0DE, 16'h0, 0);
    run_txn(0, 0, 0, 3'd1, 2'd1, 0, 2'd0, 2'd0, 2'b00, 3, 32'h0, 16'h0F0F, 16'h0, 0);
    run_txn(0, 0, 0, 3'd1, 2'd2, 1, 2'd1, 2'd2, 2'b10, 5, 32'h0, 16'h7777, 16'h0, 0);
    run_txn(0, 1, 0, 3'd0, 2'd1, 0, 2'd0, 2'd0, 2'b00, 1, 32'h0, 16'h1111, 16'h2222, 0);
    run_txn(1, 1, 0, 3'd0, 2'd2, 0, 2'd2, 2'd1, 2'b00, 0, 32'hDEAD_BEEF, 16'h0, 16'h0, 0);
    run_txn(0, 1, 0, 3'd0, 2'd3, 0, 2'd0, 2'd0, 2'b00, 2, 32'h0, 16'h3344, 16'h5566, 0);
    run_txn(0, 1, 0, 3'd1, 2'd1, 0, 2'd0, 2'd0, 2'b00, 0, 32'h0, 16'h9ABC, 16'hFFFF, 0);
    run_txn(1, 1, 0, 3'd0, 2'd0, 1, 2'd0, 2'd0, 2'b10, 2, 32'h1234_5678, 16'h0, 16'h0, 0);
    run_txn(0, 0, 0, 3'd4, 2'd2, 0, 2'd1, 2'd1, 2'b00, 0, 32'h0, 16'h4444, 16'h0, 1);

    for (int n = 0; n < 40; n++) begin
      logic [2:0] ra;
      ra = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom);
      run_txn(1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0), ra, 2'($urandom),
              1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
              ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 4)) : 0,
              $urandom, 16'($urandom), 16'($urandom), 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule